// File: doc/BRIEF.md
# Transition-Mode PFC Gate Timer

This block is the digital timing core of a boost power-factor stage that runs at the boundary between continuous and discontinuous conduction. It takes comparator flags that arrive from the analog front end without regard to the system clock. These are a zero-current edge from the inductor's auxiliary winding, a peak current limit, the end of the ramp compare, output overvoltage, two burst-mode compensation flags, a line-range flag and an off request. It also takes a synchronous enable. From these it produces one gate-enable bit that a gate buffer outside the block turns into drive.

Every period starts either on a zero-current edge or, when no edge has come for 50 µs of gate-low time, on a restart timeout. Every period ends on the earliest of four events: the ramp compare, the current limit once its blanking window has passed, a line-dependent maximum on-time, or an inhibit. Minimum off-time and minimum period are enforced between on-periods. All timer constants are derived from a clock-frequency parameter `CLK_MHZ`.

The controller is one state machine with four states. `ST_IDLE` is disabled. `ST_ON` means the gate is high. `ST_OFF_MIN` covers the minimum off-time and minimum period. `ST_WAIT` means the gate is low and the controller waits for a trigger. The transitions are:
- IDLE to WAIT when enabled.
- ON to OFF_MIN on a terminate event.
- OFF_MIN to ON when the spacing is met and a trigger is present without inhibit.
- OFF_MIN to WAIT when the spacing is met otherwise.
- WAIT to ON on a trigger without inhibit.
- Any state to IDLE when enable is low.

Top module: `pfc_gate_timer`

## Requirements
- R1: A rising edge of the synchronized zero-current flag starts an on-period as soon as minimum off-time, minimum period and every inhibit allow it.
- R2: When the gate has been low for 50 µs (5000 cycles at 100 MHz) with no zero-current trigger, the gate turns on; the low time is then exactly 5000 cycles.
- R3: The gate is high for at most 25 µs while `line_high_a` is 0 and at most 8 µs while it is 1; reaching the limit ends the on-period.
- R4: The gate stays low for at least 1 µs after every turn-off. A zero-current edge arriving in that window is held and starts the next on-period exactly when the window expires.
- R5: Rising gate edges are at least 4 µs apart, which caps the switching frequency at 250 kHz.
- R6: The current-limit flag has no effect during the first 250 ns of an on-period. After that window it ends the on-period within the synchronizer delay plus one cycle.
- R7: The ramp-compare flag ends the on-period; when it is held high, each on-period lasts one clock cycle.
- R8: While the overvoltage flag is set, switching stops. The flag must stay at one level for 50 µs before either setting or clearing takes effect.
- R9: `comp_low_a` high stops switching. It restarts only after `comp_ok_a` goes high, and a state in which both flags are low keeps the previous mode.
- R10: An off request stops switching only after it has persisted for `OFFREQ_DB_US` microseconds. Switching resumes as soon as the request clears.
- R11: While `en` is low the gate is low from the next clock edge and all timers are cleared, so after re-enable the first restart comes 5000 cycles later. Reset also holds the gate low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous global enable |
| zcd_a | input | 1 | Zero-current detect flag (asynchronous) |
| ilim_a | input | 1 | Peak current-limit flag (asynchronous) |
| ramp_end_a | input | 1 | Ramp-compare end-of-on flag (asynchronous) |
| ovp_a | input | 1 | Output overvoltage flag, hysteretic (asynchronous) |
| comp_low_a | input | 1 | Compensation below burst stop level (asynchronous) |
| comp_ok_a | input | 1 | Compensation above burst restart level (asynchronous) |
| line_high_a | input | 1 | 1 = high line range, 0 = low line (asynchronous) |
| off_req_a | input | 1 | External stage-off request (asynchronous) |
| gate | output | 1 | Gate enable, high during an on-period |

## Verification
A zero-current edge can coincide with the end of the minimum off-time. The hazard is that the held edge is dropped, or that it waits for the restart timer. The bench provokes this with a single zero-current pulse right after a full-length on-period, so that the 4 µs period is already satisfied. It then requires the low time to equal exactly the 1 µs window. A second coincidence comes from holding the ramp compare high while zero-current edges arrive every microsecond. Here turn-off and the queued turn-on contend at each period boundary, and the bench requires one-cycle pulses spaced exactly 400 cycles apart.

// File: rtl/pfc_gt_pkg.sv
package pfc_gt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ON      = 2'd1,
        ST_OFF_MIN = 2'd2,
        ST_WAIT    = 2'd3
    } gt_state_e;

    // positions of the comparator flags in the synchronizer vector
    localparam int N_IN    = 8;
    localparam int I_ZCD   = 0;
    localparam int I_ILIM  = 1;
    localparam int I_RAMP  = 2;
    localparam int I_OVP   = 3;
    localparam int I_CLOW  = 4;
    localparam int I_COK   = 5;
    localparam int I_LINE  = 6;
    localparam int I_OFFRQ = 7;

endpackage

// File: rtl/pfc_gt_sync.sv
module pfc_gt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d[i]};
            end
            assign q[i] = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pfc_gt_debounce.sv
module pfc_gt_debounce #(
    parameter int HOLD_CYC   = 16,
    parameter bit FAST_CLEAR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;
    logic          filt_q;

    generate
        if (FAST_CLEAR) begin : g_fast
            // set needs HOLD_CYC stable cycles, clear acts at once
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt    <= '0;
                    filt_q <= 1'b0;
                end else if (!raw) begin
                    cnt    <= '0;
                    filt_q <= 1'b0;
                end else if (filt_q) begin
                    cnt    <= '0;
                end else if (cnt == LAST) begin
                    cnt    <= '0;
                    filt_q <= 1'b1;
                end else begin
                    cnt    <= cnt + 1'b1;
                end
            end
        end else begin : g_sym
            // both directions need HOLD_CYC stable cycles
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt    <= '0;
                    filt_q <= 1'b0;
                end else if (raw == filt_q) begin
                    cnt    <= '0;
                end else if (cnt == LAST) begin
                    cnt    <= '0;
                    filt_q <= raw;
                end else begin
                    cnt    <= cnt + 1'b1;
                end
            end
        end
    endgenerate

    assign filt = filt_q;

    // R8 / R10: a set of the filtered flag follows a high raw input
    assert_rise_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_q) |-> $past(raw));

endmodule

// File: rtl/pfc_gate_timer.sv
module pfc_gate_timer #(
    parameter int CLK_MHZ      = 100,
    parameter int OFFREQ_DB_US = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic zcd_a,
    input  logic ilim_a,
    input  logic ramp_end_a,
    input  logic ovp_a,
    input  logic comp_low_a,
    input  logic comp_ok_a,
    input  logic line_high_a,
    input  logic off_req_a,
    output logic gate
);

    import pfc_gt_pkg::*;

    localparam int RESTART_CYC  = 50 * CLK_MHZ;
    localparam int TON_LO_CYC   = 25 * CLK_MHZ;
    localparam int TON_HI_CYC   = 8 * CLK_MHZ;
    localparam int TOFF_MIN_CYC = CLK_MHZ;
    localparam int TPER_MIN_CYC = 4 * CLK_MHZ;
    localparam int BLANK_RAW    = (250 * CLK_MHZ) / 1000;
    localparam int BLANK_CYC    = (BLANK_RAW < 1) ? 1 : BLANK_RAW;
    localparam int OVP_DB_CYC   = 50 * CLK_MHZ;
    localparam int OFF_DB_CYC   = OFFREQ_DB_US * CLK_MHZ;

    localparam int ON_W  = $clog2(TON_LO_CYC + 1);
    localparam int OFF_W = $clog2(RESTART_CYC);
    localparam int PER_W = $clog2(TPER_MIN_CYC);

    localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(RESTART_CYC - 1);
    localparam logic [OFF_W-1:0] OFF_MIN = OFF_W'(TOFF_MIN_CYC - 1);
    localparam logic [PER_W-1:0] PER_SAT = PER_W'(TPER_MIN_CYC - 1);
    localparam logic [ON_W-1:0]  TON_LO  = ON_W'(TON_LO_CYC);
    localparam logic [ON_W-1:0]  TON_HI  = ON_W'(TON_HI_CYC);
    localparam logic [ON_W-1:0]  BLANK   = ON_W'(BLANK_CYC);

    // ---------------- input conditioning ----------------
    logic [N_IN-1:0] raw_vec, syn_vec;

    assign raw_vec[I_ZCD]   = zcd_a;
    assign raw_vec[I_ILIM]  = ilim_a;
    assign raw_vec[I_RAMP]  = ramp_end_a;
    assign raw_vec[I_OVP]   = ovp_a;
    assign raw_vec[I_CLOW]  = comp_low_a;
    assign raw_vec[I_COK]   = comp_ok_a;
    assign raw_vec[I_LINE]  = line_high_a;
    assign raw_vec[I_OFFRQ] = off_req_a;

    pfc_gt_sync #(.W(N_IN), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (syn_vec)
    );

    logic zcd_s, ilim_s, ramp_s, clow_s, cok_s, line_s;
    assign zcd_s  = syn_vec[I_ZCD];
    assign ilim_s = syn_vec[I_ILIM];
    assign ramp_s = syn_vec[I_RAMP];
    assign clow_s = syn_vec[I_CLOW];
    assign cok_s  = syn_vec[I_COK];
    assign line_s = syn_vec[I_LINE];

    logic ovp_db, off_db;

    pfc_gt_debounce #(.HOLD_CYC(OVP_DB_CYC), .FAST_CLEAR(1'b0)) u_ovp_db (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (syn_vec[I_OVP]),
        .filt  (ovp_db)
    );

    pfc_gt_debounce #(.HOLD_CYC(OFF_DB_CYC), .FAST_CLEAR(1'b1)) u_off_db (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (syn_vec[I_OFFRQ]),
        .filt  (off_db)
    );

    // burst hysteresis: stop flag wins, restart flag clears
    logic burst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      burst <= 1'b0;
        else if (clow_s) burst <= 1'b1;
        else if (cok_s)  burst <= 1'b0;
    end

    logic zcd_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zcd_prev <= 1'b0;
        else        zcd_prev <= zcd_s;
    end

    // ---------------- timing decisions ----------------
    gt_state_e        state, nxt;
    logic [ON_W-1:0]  on_cnt;
    logic [OFF_W-1:0] off_cnt;
    logic [PER_W-1:0] per_cnt;
    logic             zcd_pend;

    logic             zcd_rise, inhibit, on_done, ilim_hit;
    logic             start_ok, restart_due, trig, stop_now;
    logic [ON_W-1:0]  ton_lim;

    assign zcd_rise    = zcd_s & ~zcd_prev;
    assign inhibit     = ovp_db | off_db | burst;
    assign ton_lim     = line_s ? TON_HI : TON_LO;
    assign on_done     = on_cnt >= (ton_lim - 1'b1);
    assign ilim_hit    = ilim_s && (on_cnt >= BLANK);
    assign stop_now    = ramp_s | ilim_hit | on_done | inhibit;
    assign start_ok    = (off_cnt >= OFF_MIN) && (per_cnt >= PER_SAT);
    assign restart_due = off_cnt >= OFF_SAT;
    assign trig        = zcd_rise | zcd_pend | restart_due;

    // ---------------- state machine ----------------
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_WAIT;
                ST_ON:      if (stop_now) nxt = ST_OFF_MIN;
                ST_OFF_MIN: if (start_ok) nxt = (trig && !inhibit) ? ST_ON : ST_WAIT;
                ST_WAIT:    if (trig && !inhibit && start_ok) nxt = ST_ON;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // on-time, off-time and period counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_cnt   <= '0;
            off_cnt  <= '0;
            per_cnt  <= PER_SAT;
            zcd_pend <= 1'b0;
        end else begin
            if (state != ST_ON) on_cnt <= '0;
            else                on_cnt <= on_cnt + 1'b1;

            if (state == ST_ON || state == ST_IDLE) off_cnt <= '0;
            else if (off_cnt != OFF_SAT)             off_cnt <= off_cnt + 1'b1;

            if (state == ST_IDLE)                      per_cnt <= PER_SAT;
            else if (nxt == ST_ON && state != ST_ON)  per_cnt <= '0;
            else if (per_cnt != PER_SAT)               per_cnt <= per_cnt + 1'b1;

            if (state == ST_IDLE || nxt == ST_ON) zcd_pend <= 1'b0;
            else if (zcd_rise)                    zcd_pend <= 1'b1;
        end
    end

    // output process
    always_comb begin
        gate = (state == ST_ON);
    end

    // ---------------- assertions ----------------
    assert_en_low_gate_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate);

    assert_ton_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && on_cnt >= ton_lim - 1'b1) |=> !gate);

    assert_min_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> ($past(off_cnt) >= OFF_MIN));

    assert_min_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> ($past(per_cnt) >= PER_SAT));

    assert_blank_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && en && on_cnt < BLANK && ilim_s && !ramp_s && !inhibit && !on_done) |=> gate);

    assert_ovp_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_db |=> !gate);

    assert_burst_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        burst |=> !gate);

    assert_offreq_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        off_db |=> !gate);

endmodule

// File: tb/pfc_gate_timer_tb.sv
module pfc_gate_timer_tb;

    localparam int CLK_MHZ = 100;
    localparam int OFF_US  = 20;
    localparam int RESTART = 50 * CLK_MHZ;
    localparam int TPER    = 4 * CLK_MHZ;
    localparam int TOFF    = CLK_MHZ;
    localparam int TON_LO  = 25 * CLK_MHZ;

    // vector table: line range and expected maximum on-time in microseconds
    localparam int VEC_LINE   [4] = '{0, 1, 1, 0};
    localparam int VEC_TON_US [4] = '{25, 8, 8, 25};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, en, ilim_a, ramp_end_a, ovp_a, comp_low_a, comp_ok_a;
    logic line_high_a, off_req_a, gate;
    logic zcd_gen = 1'b0, zcd_pulse = 1'b0, zcd_run = 1'b0;
    logic zcd_a;
    assign zcd_a = zcd_gen | zcd_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    pfc_gate_timer #(.CLK_MHZ(CLK_MHZ), .OFFREQ_DB_US(OFF_US)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .zcd_a       (zcd_a),
        .ilim_a      (ilim_a),
        .ramp_end_a  (ramp_end_a),
        .ovp_a       (ovp_a),
        .comp_low_a  (comp_low_a),
        .comp_ok_a   (comp_ok_a),
        .line_high_a (line_high_a),
        .off_req_a   (off_req_a),
        .gate        (gate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (gate === lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise();
        while (gate !== 1'b0) @(negedge clk);
        while (gate !== 1'b1) @(negedge clk);
    endtask

    task automatic count_rises(input int cyc, output int n);
        logic prev;
        n = 0;
        prev = gate;
        repeat (cyc) begin
            @(negedge clk);
            if (gate && !prev) n++;
            prev = gate;
        end
    endtask

    // zero-current generator: a rising edge every 100 cycles while enabled
    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            if (zcd_run) begin
                c++;
                if (c >= 50) begin
                    zcd_gen = ~zcd_gen;
                    c = 0;
                end
            end else begin
                zcd_gen = 1'b0;
                c = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; en = 1'b0; ilim_a = 1'b0; ramp_end_a = 1'b0; ovp_a = 1'b0;
        comp_low_a = 1'b0; comp_ok_a = 1'b0; line_high_a = 1'b0; off_req_a = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 gate low in reset", int'(gate), 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk("R11 gate low while disabled", int'(gate), 0);

        // first period after enable comes from the restart timer
        en = 1'b1;
        @(negedge clk);
        count_level(1'b0, n);
        chk("R2 R11 restart after enable", n, RESTART);
        count_level(1'b1, n);
        chk("R3 low-line on-time", n, TON_LO);

        // table walk: restart gap and maximum on-time per line range
        for (int i = 0; i < 4; i++) begin
            line_high_a = (VEC_LINE[i] != 0);
            count_level(1'b0, n);
            chk("R2 restart gap", n, RESTART);
            count_level(1'b1, n);
            chk("R3 max on-time by line", n, VEC_TON_US[i] * CLK_MHZ);
        end

        // zero-current edge inside the minimum off window is held
        fork
            begin
                zcd_pulse = 1'b1;
                repeat (10) @(negedge clk);
                zcd_pulse = 1'b0;
            end
            begin
                count_level(1'b0, n);
            end
        join
        chk("R1 R4 held edge starts at min off", n, TOFF);
        count_level(1'b1, n);
        chk("R3 on-time after edge start", n, TON_LO);

        // frequency cap with closely spaced edges and ramp compare held
        ramp_end_a = 1'b1;
        zcd_run = 1'b1;
        wait_rise();
        wait_rise();
        for (int k = 0; k < 2; k++) begin
            count_level(1'b1, n);
            chk("R7 ramp compare one-cycle pulse", n, 1);
            count_level(1'b0, n);
            chk("R5 period capped at 400 cycles", n, TPER - 1);
        end

        // blanking of an early current-limit pulse
        ramp_end_a = 1'b0;
        zcd_run = 1'b0;
        repeat (200) @(negedge clk);
        wait_rise();
        fork
            begin
                ilim_a = 1'b1;
                repeat (5) @(negedge clk);
                ilim_a = 1'b0;
            end
            begin
                count_level(1'b1, n);
            end
        join
        chk("R6 early limit ignored", n, TON_LO);
        count_level(1'b0, n);
        fork
            begin
                repeat (100) @(negedge clk);
                ilim_a = 1'b1;
                repeat (4) @(negedge clk);
                ilim_a = 1'b0;
            end
            begin
                count_level(1'b1, n);
            end
        join
        chk_range("R6 late limit ends on-period", n, 101, 106);

        // overvoltage with debounce
        ramp_end_a = 1'b1;
        zcd_run = 1'b1;
        repeat (1000) @(negedge clk);
        ovp_a = 1'b1;
        count_rises(4000, n);
        chk_range("R8 switching before debounce", n, 1, 100);
        repeat (1500) @(negedge clk);
        count_rises(3000, n);
        chk("R8 stopped while overvoltage", n, 0);
        ovp_a = 1'b0;
        repeat (5500) @(negedge clk);
        count_rises(2000, n);
        chk_range("R8 resumes after clear", n, 1, 100);

        // burst hysteresis
        comp_low_a = 1'b1;
        repeat (20) @(negedge clk);
        comp_low_a = 1'b0;
        repeat (10) @(negedge clk);
        count_rises(2000, n);
        chk("R9 stopped in hysteresis band", n, 0);
        comp_ok_a = 1'b1;
        repeat (10) @(negedge clk);
        count_rises(2000, n);
        chk_range("R9 restart above level", n, 1, 100);
        comp_ok_a = 1'b0;
        count_rises(2000, n);
        chk_range("R9 running in hysteresis band", n, 1, 100);

        // off request
        off_req_a = 1'b1;
        count_rises(1500, n);
        chk_range("R10 running during debounce", n, 1, 100);
        repeat (700) @(negedge clk);
        count_rises(3000, n);
        chk("R10 stopped after debounce", n, 0);
        off_req_a = 1'b0;
        count_rises(1000, n);
        chk_range("R10 resumes on clear", n, 1, 100);

        // enable low forces gate low and clears timers
        en = 1'b0;
        @(negedge clk);
        chk("R11 gate low next cycle", int'(gate), 0);
        count_rises(1000, n);
        chk("R11 no switching while disabled", n, 0);
        zcd_run = 1'b0;
        ramp_end_a = 1'b0;
        repeat (20) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        count_level(1'b0, n);
        chk("R11 timers restart from enable", n, RESTART);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule